// File: doc/BRIEF.md
# Infrared Pulse Transmitter

This block turns a queue of timed mark and space entries into a single consumer-infrared output. Software writes entries through a small register write port. Each entry is a 13-bit word. It holds a mark/space flag, a 2-bit unit selector and a duration. Entries wait in an internal FIFO and are played strictly in order, one after the next, with no idle cycle between them. During a mark the output carries a carrier. The carrier's high and low lengths are programmable and counted in modulator ticks. During a space the output rests at the idle level.

Durations count microsecond strobes of 1, 10 or 100 µs, or whole carrier periods. Because of the last option, a mark can last an exact number of carrier cycles. The carrier restarts at the beginning of its high phase each time an entry starts. A soft-reset input empties the queue and stops playback between batches, and leaves the control and carrier settings as they are. A status word reports whether the queue is empty, whether an entry is playing, and whether a push was lost.

Top module: `ir_tx_top`

## Requirements
- R1: A write to address 2 pushes `wr_data[12:0]` as an entry only when `wr_data[16]` is 1. With bit 16 at 0 the write has no effect.
- R2: Each entry has its duration minus one in bits [9:0], its unit in bits [11:10], and bit 12 set to 1 for a mark or 0 for a space. Entries play in push order, and each lasts duration-minus-one plus one units.
- R3: A push while the FIFO is full is dropped and sets a sticky overflow flag, status bit 25.
- R4: Unit codes 0, 1 and 2 count strobes on `tick_1us`, `tick_10us` and `tick_100us` respectively.
- R5: Unit code 3 counts whole carrier periods, so a mark of N+1 periods lasts exactly (N+1)·(H+L) modulator ticks.
- R6: Address 1 sets the carrier high count H as bits [31:16] plus one and the low count L as bits [15:0] plus one. At reset both counts are 13. Every entry starts the carrier at the start of its high phase.
- R7: Control bits [13:12] choose the modulator tick: 0 is every clock, 1 is `tick_x3`, 2 is `tick_1us` and 3 is `tick_10us`.
- R8: Control bit 2 sets the idle level. During a space, or whenever nothing plays, `ir_out` equals that level. During a mark, `ir_out` is its inverse while the carrier is high.
- R9: Control bit 0 enables playback. While it is 0 no entry starts, and clearing it stops the current entry in the next cycle.
- R10: A high `soft_rst` empties the FIFO, stops the current entry and clears the overflow flag. It leaves the control and carrier settings unchanged.
- R11: In the status word, bit 24 is 1 when the FIFO is empty, bit 26 is 1 while an entry plays, and bit 25 is the overflow flag. All other bits are 0, so after reset the word is 0x01000000.
- R12: When an entry ends and the FIFO holds another entry, the next entry starts on the same clock edge, leaving no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Clears the queue, the playback and the overflow flag |
| tick_x3 | input | 1 | Crystal/3 strobe, used as a modulator tick source |
| tick_1us | input | 1 | 1 µs strobe |
| tick_10us | input | 1 | 10 µs strobe |
| tick_100us | input | 1 | 100 µs strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 carrier, 2 entry |
| wr_data | input | 32 | Register write data |
| ir_out | output | 1 | Infrared drive output |
| status | output | 32 | Status word |

## Verification
The bench builds the block with an 8-entry FIFO. With that depth, a ninth push already reaches the overflow and drop path, while random batches of up to six entries still fit. The carrier counts stay between 1 and 4, so carrier-period durations and carrier-phase alignment can be compared cycle by cycle over short traces. The tick strobes are held or pulsed directly by the bench. This makes each unit selector and modulator source distinguishable: a frozen source must stall the entry or the carrier indefinitely.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    localparam int DUR_W    = 10;
    localparam int CAR_W    = 16;
    localparam int ENTRY_W  = 13;
    localparam int PUSH_BIT = 16;
    localparam int ST_EMPTY = 24;
    localparam int ST_OVF   = 25;
    localparam int ST_BUSY  = 26;
    localparam int CB_EN    = 0;
    localparam int CB_IDLE  = 2;
    localparam int CB_MTB_L = 12;
    localparam logic [CAR_W-1:0] CAR_RST_M1 = CAR_W'(12);

    typedef enum logic [1:0] {
        U_1US     = 2'd0,
        U_10US    = 2'd1,
        U_100US   = 2'd2,
        U_CARRIER = 2'd3
    } unit_sel_e;

    typedef enum logic [1:0] {
        M_CLK   = 2'd0,
        M_X3    = 2'd1,
        M_1US   = 2'd2,
        M_10US  = 2'd3
    } mod_sel_e;

    typedef enum logic [1:0] {
        A_CTRL    = 2'd0,
        A_CARRIER = 2'd1,
        A_ENTRY   = 2'd2,
        A_SPARE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             mark;
        unit_sel_e        unit;
        logic [DUR_W-1:0] dur_m1;
    } entry_t;

    function automatic entry_t to_entry(logic [ENTRY_W-1:0] w);
        return entry_t'(w);
    endfunction

    function automatic logic [31:0] make_status(logic empty, logic ovf, logic busy);
        logic [31:0] s;
        s = '0;
        s[ST_EMPTY] = empty;
        s[ST_OVF]   = ovf;
        s[ST_BUSY]  = busy;
        return s;
    endfunction

endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   push,
    input  entry_t din,
    input  logic   pop,
    output entry_t head,
    output logic   empty,
    output logic   full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    entry_t        mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULLC);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
    import ir_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             mod_tick,
    input  logic [CAR_W-1:0] hi_m1,
    input  logic [CAR_W-1:0] lo_m1,
    output logic             car_hi,
    output logic             period_end
);
    logic [CAR_W-1:0] cnt;

    assign period_end = mod_tick && !car_hi && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            car_hi <= 1'b1;
            cnt    <= '0;
        end else if (restart) begin
            car_hi <= 1'b1;
            cnt    <= hi_m1;
        end else if (mod_tick) begin
            if (cnt == '0) begin
                car_hi <= !car_hi;
                cnt    <= car_hi ? lo_m1 : hi_m1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq
    import ir_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   en,
    input  logic   q_empty,
    input  entry_t q_head,
    input  logic   t1,
    input  logic   t10,
    input  logic   t100,
    input  logic   period_end,
    output logic   load,
    output logic   busy,
    output logic   cur_mark
);
    logic [DUR_W-1:0] cnt;
    unit_sel_e        unit;
    logic             unit_tick, done;

    always_comb begin
        unique case (unit)
            U_1US:     unit_tick = t1;
            U_10US:    unit_tick = t10;
            U_100US:   unit_tick = t100;
            default:   unit_tick = period_end;
        endcase
    end

    assign done = busy && unit_tick && (cnt == '0);
    assign load = en && !q_empty && (!busy || done);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy     <= 1'b0;
            cnt      <= '0;
            unit     <= U_1US;
            cur_mark <= 1'b0;
        end else if (!en) begin
            busy <= 1'b0;
        end else if (load) begin
            busy     <= 1'b1;
            cnt      <= q_head.dur_m1;
            unit     <= q_head.unit;
            cur_mark <= q_head.mark;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy && unit_tick) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ir_tx_top.sv
module ir_tx_top
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        tick_x3,
    input  logic        tick_1us,
    input  logic        tick_10us,
    input  logic        tick_100us,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        ir_out,
    output logic [31:0] status
);
    logic             ctrl_en, ctrl_idle;
    mod_sel_e         ctrl_mtb;
    logic [CAR_W-1:0] car_hi_m1, car_lo_m1;
    logic             ovf;
    logic             push_req, push_drop;
    logic             q_empty, q_full, load, busy, cur_mark;
    logic             car_hi, period_end, mod_tick;
    entry_t           q_head;
    reg_addr_e        waddr;

    assign waddr     = reg_addr_e'(wr_addr);
    assign push_req  = wr_en && (waddr == A_ENTRY) && wr_data[PUSH_BIT];
    assign push_drop = push_req && q_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en   <= 1'b0;
            ctrl_idle <= 1'b0;
            ctrl_mtb  <= M_CLK;
            car_hi_m1 <= CAR_RST_M1;
            car_lo_m1 <= CAR_RST_M1;
        end else if (wr_en) begin
            if (waddr == A_CTRL) begin
                ctrl_en   <= wr_data[CB_EN];
                ctrl_idle <= wr_data[CB_IDLE];
                ctrl_mtb  <= mod_sel_e'(wr_data[CB_MTB_L +: 2]);
            end
            if (waddr == A_CARRIER) begin
                car_hi_m1 <= wr_data[31:16];
                car_lo_m1 <= wr_data[15:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) ovf <= 1'b0;
        else if (push_drop)  ovf <= 1'b1;
    end

    always_comb begin
        unique case (ctrl_mtb)
            M_CLK:   mod_tick = 1'b1;
            M_X3:    mod_tick = tick_x3;
            M_1US:   mod_tick = tick_1us;
            default: mod_tick = tick_10us;
        endcase
    end

    ir_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(push_req), .din(to_entry(wr_data[ENTRY_W-1:0])),
        .pop(load), .head(q_head), .empty(q_empty), .full(q_full)
    );

    ir_tx_seq u_seq (
        .clk(clk), .rst(rst), .clr(soft_rst), .en(ctrl_en),
        .q_empty(q_empty), .q_head(q_head),
        .t1(tick_1us), .t10(tick_10us), .t100(tick_100us),
        .period_end(period_end),
        .load(load), .busy(busy), .cur_mark(cur_mark)
    );

    ir_tx_carrier u_car (
        .clk(clk), .rst(rst), .restart(load), .mod_tick(mod_tick),
        .hi_m1(car_hi_m1), .lo_m1(car_lo_m1),
        .car_hi(car_hi), .period_end(period_end)
    );

    assign ir_out = ctrl_idle ^ (busy && cur_mark && car_hi);
    assign status = make_status(q_empty, ovf, busy);
endmodule

// File: rtl/ir_tx_chk.sv
module ir_tx_chk
    import ir_tx_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        soft_rst,
    input logic        ir_out,
    input logic [31:0] status,
    input logic        idle_lvl,
    input logic        en,
    input logic        push_drop,
    input logic        cur_mark
);
    p_idle_level_r8: assert property (@(posedge clk) disable iff (rst)
        !status[ST_BUSY] |-> (ir_out == idle_lvl));

    p_overflow_set_r3: assert property (@(posedge clk) disable iff (rst)
        (push_drop && !soft_rst) |=> status[ST_OVF]);

    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (status[ST_OVF] && !soft_rst) |=> status[ST_OVF]);

    p_soft_clear_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (status[ST_EMPTY] && !status[ST_BUSY] && !status[ST_OVF]));

    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !status[ST_BUSY]);

    p_mark_starts_high_r6: assert property (@(posedge clk) disable iff (rst)
        (status[ST_BUSY] && !$past(status[ST_BUSY]) && cur_mark) |-> (ir_out != idle_lvl));

    p_status_zero_bits_r11: assert property (@(posedge clk) disable iff (rst)
        (status & ~32'h0700_0000) == 32'h0);
endmodule

bind ir_tx_top ir_tx_chk u_chk (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ir_out(ir_out),
    .status(status), .idle_lvl(ctrl_idle), .en(ctrl_en),
    .push_drop(push_drop), .cur_mark(cur_mark)
);

// File: tb/sim_ir_tx_top.sv
`timescale 1ns/1ps
module sim_ir_tx_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        tick_x3 = 1'b0, tick_1us = 1'b1, tick_10us = 1'b0, tick_100us = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ir_out;
    logic [31:0] status;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ir_tx_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .tick_x3(tick_x3),
        .tick_1us(tick_1us), .tick_10us(tick_10us), .tick_100us(tick_100us),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ir_out(ir_out), .status(status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(bit en, bit idle, int mtb);
        return (32'(en)) | (32'(idle) << 2) | (32'(mtb & 3) << 12);
    endfunction

    function automatic logic [31:0] entry_word(bit mark, int unit, int dm1);
        return 32'h1_0000 | (32'(mark) << 12) | (32'(unit & 3) << 10) | 32'(dm1 & 10'h3ff);
    endfunction

    function automatic int unit_len(int unit, int dm1, int h, int l);
        return (unit == 3) ? (dm1 + 1) * (h + l) : (dm1 + 1);
    endfunction

    task automatic wait_busy();
        for (int i = 0; i < 30 && !status[26]; i++) @(negedge clk);
    endtask

    // random batches: R2 ordering/duration, R5 carrier units, R6 carrier shape, R8 levels, R12 no gaps
    task automatic random_trial(input int t);
        int n, h, l, total, mism, first_k;
        bit idle;
        bit mk [6];
        int un [6];
        int dm [6];
        logic expv [0:511];
        logic got_first, exp_first;
        n = 1 + int'($urandom % 6);
        h = 1 + int'($urandom % 4);
        l = 1 + int'($urandom % 4);
        idle = 1'($urandom % 2);
        pulse_soft();
        wr(2'd0, ctrl_word(0, idle, 0));
        wr(2'd1, (32'(h - 1) << 16) | 32'(l - 1));
        total = 0;
        for (int i = 0; i < n; i++) begin
            mk[i] = 1'($urandom % 2);
            un[i] = ($urandom % 2) ? 3 : 0;
            dm[i] = (un[i] == 3) ? int'($urandom % 3) : int'($urandom % 8);
            wr(2'd2, entry_word(mk[i], un[i], dm[i]));
            for (int k = 0; k < unit_len(un[i], dm[i], h, l); k++) begin
                expv[total] = mk[i] ? (idle ^ ((k % (h + l)) < h)) : idle;
                total++;
            end
        end
        wr(2'd0, ctrl_word(1, idle, 0));
        wait_busy();
        mism = 0; first_k = -1; got_first = 0; exp_first = 0;
        for (int k = 0; k < total; k++) begin
            if (ir_out !== expv[k]) begin
                if (first_k < 0) begin
                    first_k = k; got_first = ir_out; exp_first = expv[k];
                end
                mism++;
            end
            @(negedge clk);
        end
        check(mism == 0, $sformatf("R2/R5/R6/R8/R12 trial %0d cycle %0d", t, first_k),
              32'(got_first), 32'(exp_first));
        check(status == 32'h0100_0000 && ir_out == idle, $sformatf("R11 end of trial %0d", t),
              status ^ 32'(ir_out), 32'h0100_0000 ^ 32'(idle));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(status == 32'h0100_0000, "R11 reset status", status, 32'h0100_0000);
        check(ir_out == 1'b0, "R8 reset idle output", 32'(ir_out), 0);

        // R6 reset carrier 13/13: mark of one carrier period is 26 clocks
        wr(2'd2, entry_word(1, 3, 0));
        wr(2'd0, ctrl_word(1, 0, 0));
        wait_busy();
        begin
            int hi_cnt = 0, len = 0;
            while (status[26] && len < 100) begin
                if (ir_out) hi_cnt++;
                len++;
                @(negedge clk);
            end
            check(len == 26 && hi_cnt == 13, "R6 default carrier 13/13", 32'(len * 256 + hi_cnt), 32'(26 * 256 + 13));
        end

        // R1 push without bit 16 is ignored
        wr(2'd0, ctrl_word(0, 0, 0));
        wr(2'd2, entry_word(1, 0, 5) & ~32'h1_0000);
        check(status[24] == 1'b1, "R1 write without push bit ignored", status, 32'h0100_0000);
        wr(2'd0, ctrl_word(1, 0, 0));
        repeat (4) @(negedge clk);
        check(status[26] == 1'b0 && ir_out == 1'b0, "R1 nothing played", status, 32'h0100_0000);

        // R3 overflow, R10 soft reset keeps settings
        wr(2'd0, ctrl_word(0, 1, 0));
        for (int i = 0; i < DEPTH + 1; i++) wr(2'd2, entry_word(0, 0, 3));
        check(status == 32'h0200_0000, "R3 overflow after full push", status, 32'h0200_0000);
        repeat (3) @(negedge clk);
        check(status[25] == 1'b1, "R3 overflow sticky", status, 32'h0200_0000);
        pulse_soft();
        check(status == 32'h0100_0000, "R10 soft reset clears queue and flag", status, 32'h0100_0000);
        check(ir_out == 1'b1, "R10 idle setting kept", 32'(ir_out), 1);

        // R9 disabled: nothing starts, then abort mid-entry
        wr(2'd0, ctrl_word(0, 0, 0));
        wr(2'd2, entry_word(1, 0, 50));
        repeat (5) @(negedge clk);
        check(status == 32'h0, "R9 no start while disabled", status, 32'h0);
        wr(2'd0, ctrl_word(1, 0, 0));
        repeat (5) @(negedge clk);
        check(status[26] == 1'b1, "R9 plays once enabled", status, 32'h0500_0000);
        wr(2'd0, ctrl_word(0, 0, 0));
        @(negedge clk);
        check(status[26] == 1'b0 && ir_out == 1'b0, "R9 abort returns to idle", status ^ 32'(ir_out), 32'h0100_0000);

        // R4 unit 1 counts tick_10us only
        pulse_soft();
        wr(2'd2, entry_word(0, 1, 2));
        wr(2'd0, ctrl_word(1, 0, 0));
        repeat (20) @(negedge clk);
        check(status[26] == 1'b1, "R4 10us unit stalls without strobe", status, 32'h0500_0000);
        for (int i = 0; i < 3; i++) begin
            tick_10us = 1'b1; @(negedge clk); tick_10us = 1'b0;
            if (i == 1) check(status[26] == 1'b1, "R4 busy after two 10us strobes", status, 32'h0500_0000);
        end
        check(status[26] == 1'b0, "R4 done after three 10us strobes", status, 32'h0100_0000);

        // R4 unit 2 counts tick_100us only
        wr(2'd2, entry_word(1, 2, 0));
        wait_busy();
        repeat (10) @(negedge clk);
        check(status[26] == 1'b1, "R4 100us unit stalls without strobe", status, 32'h0500_0000);
        tick_100us = 1'b1; @(negedge clk); tick_100us = 1'b0;
        check(status[26] == 1'b0, "R4 done after one 100us strobe", status, 32'h0100_0000);

        // R7 modulator source 1 frozen: carrier stays high through a mark
        wr(2'd1, 32'h0000_0000);
        wr(2'd0, ctrl_word(1, 0, 1));
        wr(2'd2, entry_word(1, 0, 9));
        wait_busy();
        begin
            int hi_cnt = 0;
            for (int k = 0; k < 10; k++) begin
                if (ir_out) hi_cnt++;
                @(negedge clk);
            end
            check(hi_cnt == 10, "R7 frozen x3 source holds carrier high", 32'(hi_cnt), 10);
        end
        wr(2'd0, ctrl_word(1, 0, 0));

        for (int t = 0; t < 20; t++) random_trial(t);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule